// File: doc/BRIEF.md
# Associative Memory Pattern Matcher

This block keeps a bank of precomputed track templates. Each template lists one coarse detector coordinate (a super-strip, a group of 32 adjacent strips, grouped the same way on every layer) for each tracking layer. The block finds candidate tracks without any combinatorial search. Each hit of an event enters on its own cycle, tagged with a layer number and a super-strip. The hit is compared at once against the entry for that layer in every template. Each template keeps one flag per layer, and the flag is set when that layer has seen a matching hit.

Each comparison XORs the hit coordinate with the stored one. A per-entry resolution setting can mask off up to three low bits, so a single entry can cover several neighbouring super-strips. When the end-of-event marker arrives, every template whose count of matched layers reaches a programmable threshold is queued. The queued template addresses then leave in ascending order over a valid/ready handshake. A one-cycle done pulse marks the end of each readout. Templates are written through a simple load port.

Top module: `am_pattern_bank`

## Requirements
- R1: A load cycle (`ld_en` high) stores `ld_ss` and `ld_dc` for template `ld_addr`, layer `ld_layer`. Hits from the following cycle onward are compared against the new value.
- R2: A hit on layer L matches template p when the hit coordinate and the stored coordinate agree in every bit except the lowest `dc` bits, where `dc` is the stored 2-bit ignore count (0 to 3) of that entry. A match sets the flag of template p, layer L.
- R3: Match flags stay set for the rest of the event. A later hit on any layer leaves flags already set unchanged. A second end marker without a new start re-evaluates the same flags.
- R4: `evt_start` clears every match flag. A hit presented in the same cycle as `evt_start` counts toward the new event.
- R5: On `evt_end`, a template is queued when its number of distinct matched layers is at least `thr`. A hit presented in the same cycle as the marker is included. `thr` = 0 queues every template.
- R6: From the cycle after `evt_end`, queued addresses are presented on `out_addr` with `out_valid` high. They appear in strictly ascending order, and each address is removed by one cycle with both `out_valid` and `out_ready` high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_addr` hold their values.
- R8: `out_done` is high for exactly one cycle, once the readout queue is empty. When no template qualifies, this is the cycle right after `evt_end`. `out_valid` is low whenever `out_done` is high.
- R9: During readout (from the cycle after `evt_end` through the `out_done` cycle), `hit_valid`, `evt_start` and `evt_end` are ignored, and the match flags do not change.
- R10: After reset, `out_valid` and `out_done` are low and all match flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Template entry write strobe |
| ld_addr | input | 6 | Template address to write |
| ld_layer | input | 3 | Layer of the entry to write |
| ld_ss | input | 16 | Stored super-strip coordinate |
| ld_dc | input | 2 | Number of low coordinate bits ignored in comparison |
| thr | input | 4 | Minimum matched-layer count for a template to qualify |
| evt_start | input | 1 | Clears all match flags (new event) |
| evt_end | input | 1 | End-of-event marker; starts readout |
| hit_valid | input | 1 | Hit present this cycle |
| hit_layer | input | 3 | Layer of the hit |
| hit_ss | input | 16 | Super-strip coordinate of the hit |
| out_ready | input | 1 | Consumer accepts the presented address |
| out_valid | output | 1 | A matched template address is presented |
| out_addr | output | 6 | Matched template address |
| out_done | output | 1 | One-cycle pulse: readout finished |

## Verification
A wrong match flag only shows at the ports at the next end-of-event marker. It appears one cycle after the marker, as an address that is missing from the readout stream or should not be there. For that reason, every scenario ends events at several thresholds, so that each layer count becomes visible. A corrupted readout queue shows within one handshake as an out-of-order or repeated address, or as a done pulse that comes too early or too late. Flag corruption during readout is exposed by ending the same event a second time and comparing the two streams.

// File: rtl/am_pattern_bank.sv
module am_pattern_bank #(
  parameter int NLAYER = 8,
  parameter int CW     = 16,
  parameter int NPAT   = 64,
  parameter int DCW    = 2,
  localparam int LW = $clog2(NLAYER),
  localparam int AW = $clog2(NPAT),
  localparam int TW = $clog2(NLAYER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [LW-1:0] ld_layer,
  input  logic [CW-1:0] ld_ss,
  input  logic [DCW-1:0] ld_dc,
  input  logic [TW-1:0] thr,
  input  logic          evt_start,
  input  logic          evt_end,
  input  logic          hit_valid,
  input  logic [LW-1:0] hit_layer,
  input  logic [CW-1:0] hit_ss,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          out_done
);

  localparam int DEPTH = 2 ** (AW + LW);

  logic [CW-1:0]  ss_mem [DEPTH];
  logic [DCW-1:0] dc_mem [DEPTH];

  logic [NPAT*NLAYER-1:0] flags, flags_nx;
  logic [NPAT-1:0]        qual, pend;
  logic                   draining;
  logic [AW-1:0]          sel;
  wire                    accept = ~draining;

  always_ff @(posedge clk)
    if (ld_en) begin
      ss_mem[{ld_addr, ld_layer}] <= ld_ss;
      dc_mem[{ld_addr, ld_layer}] <= ld_dc;
    end

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    wire [CW-1:0]  st   = ss_mem[{AW'(p), hit_layer}];
    wire [DCW-1:0] dc   = dc_mem[{AW'(p), hit_layer}];
    wire [CW-1:0]  care = ~((CW'(1) << dc) - CW'(1));
    wire           hm   = accept & hit_valid & (((hit_ss ^ st) & care) == '0);
    for (genvar l = 0; l < NLAYER; l++) begin : g_lay
      assign flags_nx[p*NLAYER+l] = (flags[p*NLAYER+l] & ~(accept & evt_start))
                                  | (hm & (hit_layer == LW'(l)));
    end
    assign qual[p] = TW'($countones(flags_nx[p*NLAYER +: NLAYER])) >= thr;
  end

  always_comb begin
    sel = '0;
    for (int i = NPAT - 1; i >= 0; i--)
      if (pend[i]) sel = AW'(i);
  end

  assign out_valid = draining & (|pend);
  assign out_done  = draining & ~(|pend);
  assign out_addr  = sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags    <= '0;
      pend     <= '0;
      draining <= 1'b0;
    end else if (accept) begin
      flags <= flags_nx;
      if (evt_end) begin
        pend     <= qual;
        draining <= 1'b1;
      end
    end else begin
      if (out_valid && out_ready) pend[sel] <= 1'b0;
      if (pend == '0) draining <= 1'b0;
    end
  end

endmodule

// File: rtl/am_pattern_bank_chk.sv
module am_pattern_bank_chk #(
  parameter int NLAYER = 8,
  parameter int NPAT   = 64,
  localparam int AW = $clog2(NPAT)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   evt_start,
  input logic                   hit_valid,
  input logic                   draining,
  input logic [NPAT*NLAYER-1:0] flags,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [AW-1:0]          out_addr,
  input logic                   out_done
);

  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_start && !hit_valid && !draining) |=> (flags == '0));

  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid || (out_addr > $past(out_addr))));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  a_r9_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    draining |=> $stable(flags));

endmodule

bind am_pattern_bank am_pattern_bank_chk #(.NLAYER(NLAYER), .NPAT(NPAT)) u_chk (.*);

// File: tb/sim_am_pattern_bank.sv
module sim_am_pattern_bank;
  localparam int CLK_P = 10;
  localparam int NP = 64;
  localparam int NL = 8;

  logic clk = 0, rst_n = 0;
  logic ld_en = 0;
  logic [5:0] ld_addr = 0;
  logic [2:0] ld_layer = 0;
  logic [15:0] ld_ss = 0;
  logic [1:0] ld_dc = 0;
  logic [3:0] thr = 0;
  logic evt_start = 0, evt_end = 0, hit_valid = 0, out_ready = 0;
  logic [2:0] hit_layer = 0;
  logic [15:0] hit_ss = 0;
  logic out_valid, out_done;
  logic [5:0] out_addr;

  int checks = 0, errors = 0;
  int m_ss [NP][NL];
  int m_dc [NP][NL];
  bit m_f  [NP][NL];
  int exp_q[$];

  am_pattern_bank u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ssv(input int p, input int l);
    return (p << 8) | (l << 4);
  endfunction

  task automatic do_load(input int p, input int l, input int ss, input int dc);
    ld_en = 1; ld_addr = 6'(p); ld_layer = 3'(l); ld_ss = 16'(ss); ld_dc = 2'(dc);
    m_ss[p][l] = ss; m_dc[p][l] = dc;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic do_hit(input int l, input int ss, input bit start);
    hit_valid = 1; hit_layer = 3'(l); hit_ss = 16'(ss); evt_start = start;
    if (start) foreach (m_f[p, q]) m_f[p][q] = 0;
    for (int p = 0; p < NP; p++) begin
      int care = ~((1 << m_dc[p][l]) - 1) & 16'hFFFF;
      if (((ss ^ m_ss[p][l]) & care) == 0) m_f[p][l] = 1;
    end
    @(negedge clk);
    hit_valid = 0; evt_start = 0;
  endtask

  task automatic do_start();
    evt_start = 1;
    foreach (m_f[p, q]) m_f[p][q] = 0;
    @(negedge clk);
    evt_start = 0;
  endtask

  task automatic hit_pat(input int p, input int lo, input int hi);
    for (int l = lo; l <= hi; l++) do_hit(l, ssv(p, l), 0);
  endtask

  task automatic do_end(input int t);
    thr = 4'(t);
    exp_q.delete();
    for (int p = 0; p < NP; p++) begin
      int c = 0;
      for (int l = 0; l < NL; l++) c += m_f[p][l];
      if (c >= t) exp_q.push_back(p);
    end
    evt_end = 1;
    @(negedge clk);
    evt_end = 0;
  endtask

  task automatic drain(input bit stall, input bit inj, input string tag);
    int idx = 0;
    bit pv = 0, pr = 1, fin = 0;
    int pa = 0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (cyc == 0) begin
        if (exp_q.size() == 0) chk(out_done == 1, {"R8 done right after end ", tag}, int'(out_done), 1);
        else chk(out_valid == 1, {"R6 valid right after end ", tag}, int'(out_valid), 1);
      end
      if (out_done) begin
        chk(out_valid == 0, {"R8 no valid with done ", tag}, int'(out_valid), 0);
        chk(idx == exp_q.size(), {"R8 count at done ", tag}, idx, exp_q.size());
        fin = 1;
        break;
      end
      if (out_valid) begin
        if (idx < exp_q.size()) chk(int'(out_addr) == exp_q[idx], {"R6 address order ", tag}, int'(out_addr), exp_q[idx]);
        else chk(0, {"R6 extra address ", tag}, int'(out_addr), -1);
        if (pv && !pr) chk(int'(out_addr) == pa, {"R7 hold under stall ", tag}, int'(out_addr), pa);
      end else if (pv && !pr) chk(0, {"R7 valid dropped under stall ", tag}, 0, 1);
      out_ready = !(stall && (cyc % 3 == 0));
      if (inj && cyc == 1) begin
        hit_valid = 1; hit_layer = 0; hit_ss = 16'(ssv(60, 0)); evt_start = 1; evt_end = 1;
      end else begin
        hit_valid = 0; evt_start = 0; evt_end = 0;
      end
      if (out_valid && out_ready) idx++;
      pv = out_valid; pr = out_ready; pa = int'(out_addr);
      @(negedge clk);
    end
    hit_valid = 0; evt_start = 0; evt_end = 0;
    chk(fin, {"R8 readout finished ", tag}, int'(fin), 1);
    out_ready = 0;
    @(negedge clk);
    chk(out_done == 0, {"R8 done one cycle ", tag}, int'(out_done), 0);
  endtask

  task automatic t_reset();
    chk(out_valid == 0, "R10 valid low after reset", int'(out_valid), 0);
    chk(out_done == 0, "R10 done low after reset", int'(out_done), 0);
    do_end(1);
    drain(0, 0, "R10 no flags after reset");
  endtask

  task automatic t_full();
    do_hit(0, ssv(5, 0), 1);
    hit_pat(5, 1, 7);
    do_end(8);
    chk(exp_q.size() == 1 && exp_q[0] == 5, "R2 model full match", exp_q.size(), 1);
    drain(0, 0, "R2 full match");
  endtask

  task automatic t_thresh();
    do_start();
    hit_pat(9, 0, 6);
    hit_pat(40, 1, 7);
    hit_pat(3, 0, 5);
    do_end(7);
    drain(1, 0, "R5 thr 7");
    do_end(6);
    drain(1, 0, "R3 thr 6 same event");
    do_end(8);
    drain(0, 0, "R8 no match");
    do_end(0);
    drain(1, 0, "R5 thr 0 all");
  endtask

  task automatic t_dc();
    do_load(12, 0, ssv(12, 0), 3);
    do_hit(0, ssv(12, 0) | 7, 1);
    do_end(1);
    chk(exp_q.size() == 1 && exp_q[0] == 12, "R2 model masked", exp_q.size(), 1);
    drain(0, 0, "R2 masked low bits");
    do_hit(0, ssv(12, 0) | 8, 1);
    do_end(1);
    drain(0, 0, "R2 bit above mask");
  endtask

  task automatic t_load();
    do_load(20, 2, 16'hABC0, 0);
    do_hit(2, 16'hABC0, 1);
    do_end(1);
    drain(0, 0, "R1 new value");
    do_hit(2, ssv(20, 2), 1);
    do_end(1);
    drain(0, 0, "R1 old value gone");
  endtask

  task automatic t_start_hit();
    do_start();
    hit_pat(7, 0, 7);
    do_hit(3, ssv(5, 3), 1);
    do_end(1);
    chk(exp_q.size() == 1 && exp_q[0] == 5, "R4 model start hit", exp_q.size(), 1);
    drain(0, 0, "R4 start clears and counts hit");
  endtask

  task automatic t_ignore();
    do_start();
    hit_pat(60, 1, 7);
    hit_pat(33, 0, 7);
    hit_pat(50, 0, 7);
    do_end(8);
    drain(1, 1, "R9 inputs during readout");
    do_end(8);
    drain(0, 0, "R9 flags kept");
    do_hit(0, ssv(60, 0), 0);
    do_end(8);
    drain(0, 0, "R3 later hit completes");
  endtask

  task automatic t_end_hit();
    do_start();
    hit_pat(44, 0, 6);
    hit_valid = 1; hit_layer = 7; hit_ss = 16'(ssv(44, 7));
    m_f[44][7] = 1;
    do_end(8);
    hit_valid = 0;
    drain(0, 0, "R5 hit with end marker");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++) do_load(p, l, ssv(p, l), 0);
    foreach (m_f[p, q]) m_f[p][q] = 0;
    t_reset();
    t_full();
    t_thresh();
    t_dc();
    t_load();
    t_start_hit();
    t_ignore();
    t_end_hit();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule